// File: doc/BRIEF.md
# Fast Page Mode DRAM Controller

This block sits between a host that issues single-word read and write requests and an asynchronous fast-page-mode DRAM with a 4-bit data path. The host uses a valid/ready handshake with a write flag, a 24-bit word address and 4-bit write data. Read results return on a one-cycle response pulse, in request order. On the memory side the block drives the row strobe, the column strobe, the write enable, the output enable, a 12-bit multiplexed address and a 4-bit data bus. The data bus is split into an output, an output enable and an input.

The upper 12 address bits select the row and the lower 12 select the column. After a row is opened, later requests to the same row reuse it, and only the column strobe cycles. A request to another row closes the page first. The page also closes when the host raises the close request input, or when the row strobe low window would otherwise exceed its configured maximum. Every timing minimum and maximum is a parameter counted in system clock cycles. All strobe, address and data outputs come straight from registers.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: While reset is held, the row strobe, column strobe, write enable and output enable are high (inactive), the data output enable and response valid are low, and the request ready is low. Request ready goes high within four cycles after reset is released.
- R2: The row field (address bits 23:12) is on the memory address bus when the row strobe falls. The column field (bits 11:0) is on it when the column strobe falls. The address stays stable while the column strobe is low, and the column strobe is never low while the row strobe is high.
- R3: Every row strobe low period lasts at least T_RAS_MIN and at most T_RAS_MAX cycles, including a stream of same-row requests that outlasts the window.
- R4: The row strobe stays high for at least T_RP cycles between two row strobe low periods.
- R5: Between two column accesses in the same page, the column strobe stays high for at least T_CP cycles.
- R6: Writes use the early form. Write enable is low, and the data output enable is high with the write data, for at least one cycle before the column strobe falls. Both hold while the column strobe is low.
- R7: A read holds write enable high, keeps the column strobe low for at least T_CAS cycles, and returns the stored word at the accessed address.
- R8: Consecutive requests to the same row that fit in the window share one row strobe low period. Four back-to-back same-row writes produce exactly one row strobe fall.
- R9: A request to a different row closes the page. The column strobe is high before the row strobe rises, and each of N alternating-row requests causes its own row strobe fall.
- R10: The data output enable and a low output enable are never active in the same cycle. The data output enable is low in the cycle before output enable falls, so a read right after a write in one page returns the written word.
- R11: While the close request input is high, request ready is low, no new row is opened, and an open page is closed within six cycles.
- R12: The first column strobe fall of a page comes at least T_RCD cycles after the row strobe fall.
- R13: Each accepted read produces exactly one response pulse, and responses come back in the order the reads were accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Block accepts the request in this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 24 | Word address: row in bits 23:12, column in bits 11:0 |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read response pulse |
| rsp_rdata | output | 4 | Read data, valid with rsp_valid |
| page_close | input | 1 | Close request: close the open page and hold off new accesses |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | 12 | Multiplexed row/column address |
| dram_dq_out | output | 4 | Data driven to memory |
| dram_dq_oe | output | 1 | Data driver enable |
| dram_dq_in | input | 4 | Data returned by memory |

## Verification
The timing properties assume that the parameters fit together. T_RAS_MAX must leave room for a first column access, a precharge and a close after the row opens, and T_RCD must not be shorter than T_CP. The bench uses the defaults, which meet both. The bench also assumes the host keeps each request stable until it is accepted, and that the memory returns stored data while both the column strobe and the output enable are low. Its memory model behaves exactly that way, and its driver task holds every request field until ready is seen. The close request is only raised when no request is in progress. The bench then verifies that no row opens until the request is dropped.

// File: rtl/fpm_pkg.sv
package fpm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ROW,
    ST_CSETUP,
    ST_CSTROBE,
    ST_CPRE,
    ST_OPEN,
    ST_CLOSE,
    ST_RPRE
  } fpm_state_e;

  function automatic int fpm_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  function automatic logic fpm_ras_low(input fpm_state_e s);
    return (s != ST_IDLE) && (s != ST_RPRE);
  endfunction

endpackage

// File: rtl/fpm_sat_count.sv
module fpm_sat_count #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         inc,
  output logic [W-1:0] q
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] q_d;

  always_comb begin
    q_d = q;
    if (clr)
      q_d = '0;
    else if (inc && (q != TOP))
      q_d = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      q <= '0;
    else
      q <= q_d;
  end

endmodule

// File: rtl/fpm_page_track.sv
module fpm_page_track #(
  parameter int ROW_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] row_in,
  output logic             row_hit
);

  logic [ROW_W-1:0] open_row_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      open_row_q <= '0;
    else if (load)
      open_row_q <= row_in;
  end

  assign row_hit = (row_in == open_row_q);

endmodule

// File: rtl/fpm_seq.sv
module fpm_seq
  import fpm_pkg::*;
#(
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_AA      = 5,
  parameter int T_RAC     = 10,
  parameter int T_CP      = 2,
  parameter int T_RP      = 6,
  parameter int T_RAS_MIN = 10,
  parameter int T_RAS_MAX = 60,
  parameter int CNT_W     = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic             row_hit,
  input  logic             page_close,
  input  logic             op_write,
  input  logic [CNT_W-1:0] ras_cnt,
  input  logic [CNT_W-1:0] ph_cnt,
  output fpm_state_e       state_q,
  output fpm_state_e       state_d,
  output logic             ready,
  output logic             strobe_done
);

  // column address is on the bus one cycle before the strobe falls
  localparam int STROBE_LEN = fpm_max(T_CAS, T_AA - 1);
  // last RAS-low count at which a further column still fits, with a close
  localparam int WIN_LAST   = T_RAS_MAX - 4 - STROBE_LEN - T_CP;

  localparam logic [CNT_W-1:0] K_RCD  = CNT_W'(T_RCD - 1);
  localparam logic [CNT_W-1:0] K_STB  = CNT_W'(STROBE_LEN - 1);
  localparam logic [CNT_W-1:0] K_RAC  = CNT_W'(T_RAC - 1);
  localparam logic [CNT_W-1:0] K_CP   = CNT_W'(T_CP - 1);
  localparam logic [CNT_W-1:0] K_RP   = CNT_W'(T_RP - 1);
  localparam logic [CNT_W-1:0] K_RMIN = CNT_W'(T_RAS_MIN - 1);
  localparam logic [CNT_W-1:0] K_WIN  = CNT_W'(WIN_LAST);

  logic win_ok;

  assign win_ok      = (ras_cnt <= K_WIN);
  assign strobe_done = (state_q == ST_CSTROBE) && (ph_cnt >= K_STB) &&
                       (op_write || (ras_cnt >= K_RAC));

  always_comb begin
    state_d = state_q;
    ready   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        ready = !page_close;
        if (req_valid && !page_close)
          state_d = ST_ROW;
      end
      ST_ROW: begin
        if (ph_cnt >= K_RCD)
          state_d = ST_CSETUP;
      end
      ST_CSETUP: state_d = ST_CSTROBE;
      ST_CSTROBE: begin
        if (strobe_done)
          state_d = ST_CPRE;
      end
      ST_CPRE: begin
        if (ph_cnt >= K_CP)
          state_d = ST_OPEN;
      end
      ST_OPEN: begin
        ready = !page_close && win_ok && row_hit;
        if (page_close || !win_ok || (req_valid && !row_hit))
          state_d = ST_CLOSE;
        else if (req_valid)
          state_d = ST_CSETUP;
      end
      ST_CLOSE: begin
        if (ras_cnt >= K_RMIN)
          state_d = ST_RPRE;
      end
      ST_RPRE: begin
        if (ph_cnt >= K_RP)
          state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      state_q <= ST_IDLE;
    else
      state_q <= state_d;
  end

endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_pkg::*;
#(
  parameter int ROW_W     = 12,
  parameter int COL_W     = 12,
  parameter int DATA_W    = 4,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_AA      = 5,
  parameter int T_RAC     = 10,
  parameter int T_CP      = 2,
  parameter int T_RP      = 6,
  parameter int T_RAS_MIN = 10,
  parameter int T_RAS_MAX = 60,
  localparam int ADDR_W   = ROW_W + COL_W,
  localparam int MUX_W    = fpm_max(ROW_W, COL_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              page_close,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [MUX_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_out,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_in
);

  localparam int CNT_MAX = fpm_max(fpm_max(T_RAS_MAX, T_RP),
                                   fpm_max(T_RAC, fpm_max(T_CAS, T_AA)));
  localparam int CNT_W   = $clog2(CNT_MAX + 2);

  // reset release synchronizer
  logic [1:0] run_sync_q;
  logic       run_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      run_sync_q <= 2'b00;
    else
      run_sync_q <= {run_sync_q[0], 1'b1};
  end
  assign run_en = run_sync_q[1];

  fpm_state_e       state_q, state_d;
  logic [CNT_W-1:0] ras_cnt, ph_cnt;
  logic             seq_ready, strobe_done, row_hit, accept;

  logic              rq_write_q;
  logic [ADDR_W-1:0] rq_addr_q;
  logic [DATA_W-1:0] rq_wdata_q;

  assign req_ready = seq_ready && run_en;
  assign accept    = req_valid && req_ready;

  fpm_seq #(
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_AA(T_AA), .T_RAC(T_RAC),
    .T_CP(T_CP), .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX),
    .CNT_W(CNT_W)
  ) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid && run_en),
    .row_hit    (row_hit),
    .page_close (page_close),
    .op_write   (rq_write_q),
    .ras_cnt    (ras_cnt),
    .ph_cnt     (ph_cnt),
    .state_q    (state_q),
    .state_d    (state_d),
    .ready      (seq_ready),
    .strobe_done(strobe_done)
  );

  // cycles since the row strobe fell; zero whenever it is high
  fpm_sat_count #(.W(CNT_W)) i_ras_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (!fpm_ras_low(state_q)),
    .inc  (1'b1),
    .q    (ras_cnt)
  );

  // cycles spent in the current state
  fpm_sat_count #(.W(CNT_W)) i_ph_cnt (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_d != state_q),
    .inc  (1'b1),
    .q    (ph_cnt)
  );

  fpm_page_track #(.ROW_W(ROW_W)) i_page (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (accept && (state_q == ST_IDLE)),
    .row_in (req_addr[ADDR_W-1:COL_W]),
    .row_hit(row_hit)
  );

  // request hold register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rq_write_q <= 1'b0;
      rq_addr_q  <= '0;
      rq_wdata_q <= '0;
    end else if (accept) begin
      rq_write_q <= req_write;
      rq_addr_q  <= req_addr;
      rq_wdata_q <= req_wdata;
    end
  end

  // next values of the registered memory-side outputs
  logic              sel_write;
  logic [ADDR_W-1:0] sel_addr;
  logic [DATA_W-1:0] sel_wdata;
  logic              ras_low_d, cas_low_d, col_phase_d;
  logic [MUX_W-1:0]  addr_d;
  logic              rsp_cap;

  always_comb begin
    sel_write   = accept ? req_write : rq_write_q;
    sel_addr    = accept ? req_addr  : rq_addr_q;
    sel_wdata   = accept ? req_wdata : rq_wdata_q;
    ras_low_d   = fpm_ras_low(state_d);
    cas_low_d   = (state_d == ST_CSTROBE);
    col_phase_d = (state_d == ST_CSETUP) || (state_d == ST_CSTROBE);
    if (col_phase_d)
      addr_d = MUX_W'(sel_addr[COL_W-1:0]);
    else
      addr_d = MUX_W'(sel_addr[ADDR_W-1:COL_W]);
    rsp_cap = strobe_done && !rq_write_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_oe_n   <= 1'b1;
      dram_addr   <= '0;
      dram_dq_out <= '0;
      dram_dq_oe  <= 1'b0;
    end else begin
      dram_ras_n  <= !ras_low_d;
      dram_cas_n  <= !cas_low_d;
      dram_we_n   <= !(col_phase_d && sel_write);
      dram_oe_n   <= !(cas_low_d && !sel_write);
      dram_addr   <= addr_d;
      dram_dq_out <= sel_wdata;
      dram_dq_oe  <= col_phase_d && sel_write;
    end
  end

  // read capture at the edge that ends the column strobe
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rsp_cap;
      if (rsp_cap)
        rsp_rdata <= dram_dq_in;
    end
  end

endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int MUX_W     = 12,
  parameter int DATA_W    = 4,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_CP      = 2,
  parameter int T_RP      = 6,
  parameter int T_RAS_MIN = 10,
  parameter int T_RAS_MAX = 60
) (
  input logic              clk,
  input logic              rst_n,
  input logic              dram_ras_n,
  input logic              dram_cas_n,
  input logic              dram_we_n,
  input logic              dram_oe_n,
  input logic [MUX_W-1:0]  dram_addr,
  input logic [DATA_W-1:0] dram_dq_out,
  input logic              dram_dq_oe,
  input logic              page_close,
  input logic              req_ready
);

  logic [15:0] ras_lo, ras_hi, cas_lo, cas_hi;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_lo <= '0;
      ras_hi <= 16'hFFFF;
      cas_lo <= '0;
      cas_hi <= 16'hFFFF;
    end else begin
      ras_lo <= dram_ras_n ? 16'd0 : ((ras_lo == 16'hFFFF) ? ras_lo : ras_lo + 16'd1);
      ras_hi <= !dram_ras_n ? 16'd0 : ((ras_hi == 16'hFFFF) ? ras_hi : ras_hi + 16'd1);
      cas_lo <= dram_cas_n ? 16'd0 : ((cas_lo == 16'hFFFF) ? cas_lo : cas_lo + 16'd1);
      cas_hi <= !dram_cas_n ? 16'd0 : ((cas_hi == 16'hFFFF) ? cas_hi : cas_hi + 16'd1);
    end
  end

  assert_col_in_row_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_cas_n |-> !dram_ras_n);
  assert_col_stable_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n)) |-> $stable(dram_addr));
  assert_ras_width_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> (ras_lo >= 16'(T_RAS_MIN)) && (ras_lo <= 16'(T_RAS_MAX)));
  assert_ras_max_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_lo < 16'(T_RAS_MAX)));
  assert_ras_precharge_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (ras_hi >= 16'(T_RP)));
  assert_cas_precharge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (cas_hi >= 16'(T_CP)));
  assert_early_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_we_n) |-> ($past(!dram_we_n) && $past(dram_dq_oe) && dram_dq_oe));
  assert_wdata_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && $past(!dram_cas_n) && dram_dq_oe) |-> ($stable(dram_dq_out) && !dram_we_n));
  assert_cas_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_cas_n) |-> (cas_lo >= 16'(T_CAS)));
  assert_close_order_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dram_ras_n) |-> $past(dram_cas_n));
  assert_bus_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(dram_dq_oe && !dram_oe_n));
  assert_bus_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_oe_n) |-> !$past(dram_dq_oe));
  assert_close_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
    page_close |-> !req_ready);
  assert_rcd_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_cas_n) |-> (ras_lo >= 16'(T_RCD)));

endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(
  .MUX_W(MUX_W), .DATA_W(DATA_W), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_CP(T_CP),
  .T_RP(T_RP), .T_RAS_MIN(T_RAS_MIN), .T_RAS_MAX(T_RAS_MAX)
) i_fpm_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dram_ras_n (dram_ras_n),
  .dram_cas_n (dram_cas_n),
  .dram_we_n  (dram_we_n),
  .dram_oe_n  (dram_oe_n),
  .dram_addr  (dram_addr),
  .dram_dq_out(dram_dq_out),
  .dram_dq_oe (dram_dq_oe),
  .page_close (page_close),
  .req_ready  (req_ready)
);

// File: tb/test_fpm_dram_ctrl.sv
`timescale 1ns/1ps
module test_fpm_dram_ctrl;

  localparam int T_RCD = 3, T_CAS = 3, T_CP = 2, T_RP = 6;
  localparam int T_RAS_MIN = 10, T_RAS_MAX = 60;

  logic clk = 1'b0;
  logic rst_n;
  logic req_valid, req_ready, req_write;
  logic [23:0] req_addr;
  logic [3:0]  req_wdata;
  logic rsp_valid;
  logic [3:0] rsp_rdata;
  logic page_close;
  logic ras_n, cas_n, we_n, oe_n, dq_oe;
  logic [11:0] maddr;
  logic [3:0]  dq_out, dq_in;

  always #2.5 clk = ~clk;

  fpm_dram_ctrl i_fpm_dram_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .page_close(page_close),
    .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
    .dram_addr(maddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe), .dram_dq_in(dq_in)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // ---------------- memory model and timing monitor (negedge sampling)
  logic [3:0] mem [int];
  logic [3:0] bus_val = 4'h0;
  logic [11:0] row_l = '0;
  logic p_ras = 1, p_cas = 1, p_we = 1;
  logic [11:0] p_addr = '0;
  int lo_len = 0, hi_len = 0, chi_len = 0, clo_len = 0;
  int ras_falls = 0;
  int min_lo = 9999, max_lo = 0, min_hi = 9999, min_cp = 9999, min_clo = 9999, min_rcd = 9999;
  bit seen_rise = 0, first_col = 0, col_in_page = 0;
  int v_addr = 0, v_wr = 0, v_close = 0, v_bus = 0, v_rowaddr = 0;
  int exp_row = 0;

  assign dq_in = (!cas_n && !oe_n) ? bus_val : 4'h0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!ras_n) lo_len++; else hi_len++;
      if (!cas_n) clo_len++; else chi_len++;
      if (p_ras && !ras_n) begin
        ras_falls++;
        row_l = maddr;
        if (seen_rise && hi_len < min_hi) min_hi = hi_len;
        hi_len = 0;
        first_col = 1;
        col_in_page = 0;
      end
      if (!p_ras && ras_n) begin
        if (lo_len - 0 < min_lo) min_lo = lo_len;
        if (lo_len > max_lo) max_lo = lo_len;
        lo_len = 0;
        seen_rise = 1;
        if (!p_cas) v_close++;
      end
      if (!cas_n && ras_n) v_addr++;
      if (!cas_n && !p_cas && maddr != p_addr) v_addr++;
      if (dq_oe && !oe_n) v_bus++;
      if (p_cas && !cas_n) begin
        if (first_col) begin
          if (lo_len - 1 < min_rcd) min_rcd = lo_len - 1;
          first_col = 0;
        end
        if (col_in_page && chi_len < min_cp) min_cp = chi_len;
        chi_len = 0;
        if (!we_n) begin
          if (!dq_oe || p_we) v_wr++;
          mem[{row_l, maddr}] = dq_out;
        end else begin
          bus_val = mem.exists({row_l, maddr}) ? mem[{row_l, maddr}] : 4'h0;
        end
      end
      if (!p_cas && cas_n) begin
        if (clo_len < min_clo) min_clo = clo_len;
        clo_len = 0;
        if (!ras_n) col_in_page = 1;
      end
      p_ras = ras_n; p_cas = cas_n; p_we = we_n; p_addr = maddr;
    end
  end

  // ---------------- scoreboard
  logic [3:0] shadow [int];
  logic [3:0] exp_q [$];
  int n_reads = 0, n_rsp = 0;

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_rsp++;
      if (exp_q.size() == 0)
        chk(0, "R13 unexpected response", int'(rsp_rdata), -1);
      else begin
        logic [3:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R7 read data", int'(rsp_rdata), int'(e));
      end
    end
  end

  // called at a negedge; returns at the following negedge after acceptance
  task automatic issue(input bit w, input logic [23:0] a, input logic [3:0] d);
    req_valid = 1; req_write = w; req_addr = a; req_wdata = d;
    #1;
    while (!req_ready) begin
      @(negedge clk); #1;
    end
    if (w) shadow[int'(a)] = d;
    else begin
      exp_q.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 4'h0);
      n_reads++;
    end
    @(posedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic settle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL R13 watchdog expired actual=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int f0;
    rst_n = 0; page_close = 0; req_valid = 0; req_write = 0; req_addr = '0; req_wdata = '0;
    settle(5);
    chk(ras_n && cas_n && we_n && oe_n, "R1 strobes idle in reset", {ras_n, cas_n, we_n, oe_n}, 15);
    chk(!dq_oe && !rsp_valid, "R1 bus and response idle in reset", {dq_oe, rsp_valid}, 0);
    chk(!req_ready, "R1 ready low in reset", req_ready, 0);
    rst_n = 1;
    settle(4);
    chk(req_ready, "R1 ready after reset", req_ready, 1);

    // R8: back-to-back same-row writes in one page
    f0 = ras_falls;
    for (int i = 0; i < 4; i++) issue(1, {12'h123, 12'(i)}, 4'(i + 1));
    settle(80);
    chk(ras_falls - f0 == 1, "R8 writes share one page", ras_falls - f0, 1);

    f0 = ras_falls;
    for (int i = 0; i < 4; i++) issue(0, {12'h123, 12'(i)}, 4'h0);
    settle(80);
    chk(ras_falls - f0 == 1, "R8 reads share one page", ras_falls - f0, 1);

    // R9: alternating rows
    f0 = ras_falls;
    issue(1, {12'h0AA, 12'h005}, 4'h7);
    issue(1, {12'h0BB, 12'h005}, 4'h8);
    issue(0, {12'h0AA, 12'h005}, 4'h0);
    issue(0, {12'h0BB, 12'h005}, 4'h0);
    settle(80);
    chk(ras_falls - f0 == 4, "R9 each row miss opens a row", ras_falls - f0, 4);

    // R3: long same-row stream must be split by the window
    f0 = ras_falls;
    for (int i = 0; i < 12; i++) issue(0, {12'h123, 12'(i % 4)}, 4'h0);
    settle(80);
    chk(ras_falls - f0 >= 2, "R3 window splits long stream", ras_falls - f0, 2);

    // R10: write then read of the same word in one page
    issue(1, {12'h300, 12'h007}, 4'hC);
    issue(0, {12'h300, 12'h007}, 4'h0);
    issue(1, {12'h300, 12'h008}, 4'h3);
    issue(0, {12'h300, 12'h008}, 4'h0);
    settle(80);
    chk(v_bus == 0, "R10 driver and output enable overlap", v_bus, 0);

    // R11: close request closes an open page and holds off accesses
    issue(0, {12'h123, 12'h002}, 4'h0);
    while (exp_q.size() != 0) @(negedge clk);
    chk(!ras_n, "R11 page open before close request", ras_n, 0);
    page_close = 1;
    settle(6);
    chk(ras_n, "R11 page closed after request", ras_n, 1);
    chk(!req_ready, "R11 ready low while closing", req_ready, 0);
    f0 = ras_falls;
    req_valid = 1; req_write = 0; req_addr = {12'h0AA, 12'h005};
    settle(20);
    chk(ras_falls == f0 && ras_n, "R11 no row opened while held", ras_falls - f0, 0);
    page_close = 0;
    issue(0, {12'h0AA, 12'h005}, 4'h0);
    settle(80);

    chk(min_lo >= T_RAS_MIN, "R3 minimum RAS low", min_lo, T_RAS_MIN);
    chk(max_lo <= T_RAS_MAX, "R3 maximum RAS low", max_lo, T_RAS_MAX);
    chk(min_hi >= T_RP, "R4 RAS precharge", min_hi, T_RP);
    chk(min_cp >= T_CP, "R5 CAS precharge in page", min_cp, T_CP);
    chk(v_wr == 0, "R6 early write setup", v_wr, 0);
    chk(min_clo >= T_CAS, "R7 CAS low width", min_clo, T_CAS);
    chk(min_rcd >= T_RCD, "R12 RAS to CAS delay", min_rcd, T_RCD);
    chk(v_addr == 0, "R2 address hold and strobe nesting", v_addr, 0);
    chk(v_close == 0, "R9 CAS high before RAS rises", v_close, 0);
    chk(n_rsp == n_reads && exp_q.size() == 0, "R13 one response per read", n_rsp, n_reads);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
    $finish;
  end

endmodule